// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the 16-bit status word of an I2C controller. The master and slave engines around it report what happens on the bus as one-cycle event pulses: an acknowledge slot ending, a master byte starting to shift out, a collision, an address match of one of several kinds, Start and Stop, a byte moved into the receive buffer, a byte taken out of it, and a software write to the transmit data holding register. The block folds each pulse into the matching flag. Every flag is updated on the clock edge that follows its pulse.

Each flag has its own set and clear sources. Some flags are cleared by hardware when a Stop is seen. Three are sticky error flags that only software can clear, by writing 0 to their bit position. The receive-overflow flag comes from a single receive-transfer pulse combined with the state of the receive-buffer-full flag. Whenever a set and a clear reach one flag in the same cycle, the set wins. Software reads the packed word, and each flag is also available on a port of its own.

Top module: `i2c_stat_reg`

## Requirements
- R1: After an asynchronous active-low reset every bit of `stat_word` is 0. Bits 13, 12 and 11 read 0 at all times, including after a software write of all ones.
- R2: Bit 15 (`f_nack`) takes the value of `ack_nack` on each `ev_ack_done` pulse: 1 for NACK, 0 for ACK. Otherwise it holds, and software writes do not change it.
- R3: Bit 14 (`f_tx_busy`) is set by `ev_tx_start` and cleared by `ev_ack_done`. If both occur in one cycle, the bit ends up 1.
- R4: Bit 10 (`f_collision`) is set by `ev_collision` and holds until a software write (`sw_we`) carries 0 in bit 10. Writing 1 there has no effect. If a collision and a clearing write occur in one cycle, the bit ends up 1.
- R5: Bit 9 (`f_gen_call`) is set by `ev_gc_match`. Bit 8 (`f_addr10`) is set by `ev_addr10_match`. `ev_stop` clears both, but a set in the same cycle as the Stop wins.
- R6: An `ev_tx_write` while `engine_busy` is 1 or bit 0 (`f_tx_full`) is already 1 sets bit 7 (`f_wr_coll`) and leaves bit 0 unchanged. Otherwise the write sets bit 0. `ev_tx_start` clears bit 0, but an accepted write in the same cycle wins. Bit 7 is cleared only when software writes 0 to bit 7, and a set in the same cycle wins.
- R7: `ev_rx_xfer` sets bit 1 (`f_rx_full`). `ev_rx_read` clears bit 1, but a transfer in the same cycle wins. An `ev_rx_xfer` while bit 1 is already 1 sets bit 6 (`f_rx_ovf`). A transfer into an empty buffer leaves bit 6 unchanged. Bit 6 is cleared only when software writes 0 to bit 6, and a set in the same cycle wins.
- R8: Bit 5 (`f_data`) is cleared by `ev_addr_match`. It is set by `ev_byte_done` or `ev_slave_rx`, and a set in the same cycle as the match wins.
- R9: `ev_stop` sets bit 4 (`f_stop`) and clears bit 3 (`f_start`). `ev_start` sets bit 3 and clears bit 4. If both occur in one cycle, both bits end up 1.
- R10: Bit 2 (`f_read`) loads `addr_rw` on `ev_addr_match` and is cleared by `ev_stop`. If both occur in one cycle, the load wins.
- R11: A software write affects only bits 10, 7 and 6. All other bits ignore `sw_we` and `sw_wdata`.
- R12: Each single-bit flag output equals its bit in `stat_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ack_done | input | 1 | Acknowledge slot finished |
| ack_nack | input | 1 | Level sampled in that slot, 1 = NACK |
| ev_tx_start | input | 1 | Master byte transmission begins |
| ev_collision | input | 1 | Bus collision during a master operation |
| ev_gc_match | input | 1 | General call address received |
| ev_addr10_match | input | 1 | Second byte of a 10-bit address matched |
| ev_addr_match | input | 1 | Own device address matched |
| addr_rw | input | 1 | Direction bit of the matched address |
| ev_stop | input | 1 | Stop condition detected |
| ev_start | input | 1 | Start condition detected |
| ev_tx_write | input | 1 | Software wrote the transmit holding register |
| engine_busy | input | 1 | Engine cannot accept a transmit write |
| ev_rx_xfer | input | 1 | Received byte moved into the receive buffer |
| ev_rx_read | input | 1 | Software read the receive buffer |
| ev_byte_done | input | 1 | A transmission finished |
| ev_slave_rx | input | 1 | Slave data byte received |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 16 | Software write data |
| stat_word | output | 16 | Packed status word |
| f_nack | output | 1 | Bit 15 |
| f_tx_busy | output | 1 | Bit 14 |
| f_collision | output | 1 | Bit 10 |
| f_gen_call | output | 1 | Bit 9 |
| f_addr10 | output | 1 | Bit 8 |
| f_wr_coll | output | 1 | Bit 7 |
| f_rx_ovf | output | 1 | Bit 6 |
| f_data | output | 1 | Bit 5 |
| f_stop | output | 1 | Bit 4 |
| f_start | output | 1 | Bit 3 |
| f_read | output | 1 | Bit 2 |
| f_rx_full | output | 1 | Bit 1 |
| f_tx_full | output | 1 | Bit 0 |

## Verification
Every flag is a register that drives the readback word directly. A wrong next-state term therefore shows up in `stat_word` on the first clock edge after the offending pulse, and it is caught by a check of the whole word in the cycle after each stimulus. Wrong internal state also propagates: a buffer-full bit that is stuck at 0 hides an overflow on the next transfer, and a full-transmit bit that is stuck at 0 hides a write collision. The stimulus therefore includes back-to-back transfers, transfers into an empty buffer and a repeated transmit write. Same-cycle set and clear pairs are applied to every flag that has both, so that a reversed priority flips a bit within one cycle.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W = 16;

    // Bit positions of the packed status word; a reader decodes these.
    localparam int B_NACK   = 15;
    localparam int B_TXBUSY = 14;
    localparam int B_COLL   = 10;
    localparam int B_GCALL  = 9;
    localparam int B_ADR10  = 8;
    localparam int B_WRCOL  = 7;
    localparam int B_RXOVF  = 6;
    localparam int B_DATA   = 5;
    localparam int B_STOP   = 4;
    localparam int B_START  = 3;
    localparam int B_READ   = 2;
    localparam int B_RXFULL = 1;
    localparam int B_TXFULL = 0;

    // Number of flags that only software can clear.
    localparam int SWCLR_N = 3;

    typedef struct packed {
        logic nack;
        logic tx_busy;
        logic collision;
        logic gen_call;
        logic addr10;
        logic wr_coll;
        logic rx_ovf;
        logic data;
        logic stop;
        logic start;
        logic read;
        logic rx_full;
        logic tx_full;
    } stat_t;

    // Index into the software-clear mask.
    localparam int SC_COLL  = 0;
    localparam int SC_WRCOL = 1;
    localparam int SC_RXOVF = 2;

endpackage

// File: rtl/i2c_stat_swclr.sv
module i2c_stat_swclr
    import i2c_stat_pkg::*;
(
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [SWCLR_N-1:0] clr
);
    localparam int POS [SWCLR_N] = '{B_COLL, B_WRCOL, B_RXOVF};

    // A clear strobe fires for each sticky bit written as zero.
    for (genvar i = 0; i < SWCLR_N; i++) begin : g_clr
        assign clr[i] = sw_we && !sw_wdata[POS[i]];
    end
endmodule

// File: rtl/i2c_stat_pack.sv
module i2c_stat_pack
    import i2c_stat_pkg::*;
(
    input  stat_t             st,
    output logic [STAT_W-1:0] word
);
    always_comb begin
        word           = '0;
        word[B_NACK]   = st.nack;
        word[B_TXBUSY] = st.tx_busy;
        word[B_COLL]   = st.collision;
        word[B_GCALL]  = st.gen_call;
        word[B_ADR10]  = st.addr10;
        word[B_WRCOL]  = st.wr_coll;
        word[B_RXOVF]  = st.rx_ovf;
        word[B_DATA]   = st.data;
        word[B_STOP]   = st.stop;
        word[B_START]  = st.start;
        word[B_READ]   = st.read;
        word[B_RXFULL] = st.rx_full;
        word[B_TXFULL] = st.tx_full;
    end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ack_done,
    input  logic              ack_nack,
    input  logic              ev_tx_start,
    input  logic              ev_collision,
    input  logic              ev_gc_match,
    input  logic              ev_addr10_match,
    input  logic              ev_addr_match,
    input  logic              addr_rw,
    input  logic              ev_stop,
    input  logic              ev_start,
    input  logic              ev_tx_write,
    input  logic              engine_busy,
    input  logic              ev_rx_xfer,
    input  logic              ev_rx_read,
    input  logic              ev_byte_done,
    input  logic              ev_slave_rx,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] stat_word,
    output logic              f_nack,
    output logic              f_tx_busy,
    output logic              f_collision,
    output logic              f_gen_call,
    output logic              f_addr10,
    output logic              f_wr_coll,
    output logic              f_rx_ovf,
    output logic              f_data,
    output logic              f_stop,
    output logic              f_start,
    output logic              f_read,
    output logic              f_rx_full,
    output logic              f_tx_full
);
    stat_t st_d, st_q;
    logic [SWCLR_N-1:0] sw_clr;
    logic tx_reject;

    i2c_stat_swclr u_swclr (
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .clr      (sw_clr)
    );

    assign tx_reject = ev_tx_write && (engine_busy || st_q.tx_full);

    // Next-state: every flag follows "set beats clear".
    always_comb begin
        st_d = st_q;
        if (ev_ack_done) st_d.nack = ack_nack;

        if (ev_tx_start)      st_d.tx_busy = 1'b1;
        else if (ev_ack_done) st_d.tx_busy = 1'b0;

        if (ev_collision)             st_d.collision = 1'b1;
        else if (sw_clr[SC_COLL])     st_d.collision = 1'b0;

        if (ev_gc_match)  st_d.gen_call = 1'b1;
        else if (ev_stop) st_d.gen_call = 1'b0;

        if (ev_addr10_match) st_d.addr10 = 1'b1;
        else if (ev_stop)    st_d.addr10 = 1'b0;

        if (tx_reject)               st_d.wr_coll = 1'b1;
        else if (sw_clr[SC_WRCOL])   st_d.wr_coll = 1'b0;

        if (ev_tx_write && !tx_reject) st_d.tx_full = 1'b1;
        else if (ev_tx_start)          st_d.tx_full = 1'b0;

        if (ev_rx_xfer && st_q.rx_full) st_d.rx_ovf = 1'b1;
        else if (sw_clr[SC_RXOVF])      st_d.rx_ovf = 1'b0;

        if (ev_rx_xfer)      st_d.rx_full = 1'b1;
        else if (ev_rx_read) st_d.rx_full = 1'b0;

        if (ev_byte_done || ev_slave_rx) st_d.data = 1'b1;
        else if (ev_addr_match)          st_d.data = 1'b0;

        if (ev_stop)       st_d.stop = 1'b1;
        else if (ev_start) st_d.stop = 1'b0;

        if (ev_start)     st_d.start = 1'b1;
        else if (ev_stop) st_d.start = 1'b0;

        if (ev_addr_match) st_d.read = addr_rw;
        else if (ev_stop)  st_d.read = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    i2c_stat_pack u_pack (
        .st   (st_q),
        .word (stat_word)
    );

    assign f_nack      = st_q.nack;
    assign f_tx_busy   = st_q.tx_busy;
    assign f_collision = st_q.collision;
    assign f_gen_call  = st_q.gen_call;
    assign f_addr10    = st_q.addr10;
    assign f_wr_coll   = st_q.wr_coll;
    assign f_rx_ovf    = st_q.rx_ovf;
    assign f_data      = st_q.data;
    assign f_stop      = st_q.stop;
    assign f_start     = st_q.start;
    assign f_read      = st_q.read;
    assign f_rx_full   = st_q.rx_full;
    assign f_tx_full   = st_q.tx_full;

    // R2: acknowledge outcome captured one edge later
    assert_ack_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack_done |=> (stat_word[B_NACK] == $past(ack_nack)));

    // R3: start of transmission always leaves busy set
    assert_txbusy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_start |=> stat_word[B_TXBUSY]);

    // R4: collision flag survives anything but a zero write
    assert_coll_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[B_COLL] && !(sw_we && !sw_wdata[B_COLL])) |=> stat_word[B_COLL]);

    // R5: Stop without a new general call match clears it
    assert_gcall_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_gc_match) |=> !stat_word[B_GCALL]);

    // R6: rejected write flags a collision and keeps the full bit
    assert_wrcol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_write && (engine_busy || stat_word[B_TXFULL])) |=> stat_word[B_WRCOL]);

    // R7: transfer into a full buffer raises overflow
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_xfer && !stat_word[B_RXFULL] && !stat_word[B_RXOVF]) |=> !stat_word[B_RXOVF]);

    assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_xfer && stat_word[B_RXFULL]) |=> stat_word[B_RXOVF]);

    // R1: unimplemented positions stay zero
    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_we) |-> (stat_word[13:11] == 3'b000));
endmodule

// File: tb/sim_i2c_stat_reg.sv
module sim_i2c_stat_reg;
    import i2c_stat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // Event vector bit indices used by the table.
    localparam int E_ACK = 0, E_NACK = 1, E_TXS = 2, E_COL = 3, E_GC = 4, E_A10 = 5,
                   E_AM = 6, E_RW = 7, E_STP = 8, E_STA = 9, E_TXW = 10, E_BSY = 11,
                   E_RXX = 12, E_RXR = 13, E_BD = 14, E_SRX = 15, E_WE = 16;
    localparam int EV_W = 17;
    localparam int VEC_W = EV_W + 2 * STAT_W;
    localparam int N_VEC = 28;

    function automatic logic [EV_W-1:0] ev(input int a, input int b = -1, input int c = -1);
        logic [EV_W-1:0] v = '0;
        v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        return v;
    endfunction

    // {events, software write data, expected word after the edge}
    localparam logic [VEC_W-1:0] VEC [N_VEC] = '{
        {ev(E_STA),               16'h0000, 16'h0008},
        {ev(E_AM, E_RW),          16'h0000, 16'h000C},
        {ev(E_RXX),               16'h0000, 16'h000E},
        {ev(E_RXX),               16'h0000, 16'h004E},
        {ev(E_RXR),               16'h0000, 16'h004C},
        {ev(E_RXX),               16'h0000, 16'h004E},
        {ev(E_WE),                16'h0000, 16'h000E},
        {ev(E_RXR, E_RXX),        16'h0000, 16'h004E},
        {ev(E_WE),                16'hFFBF, 16'h000E},
        {ev(E_GC, E_STP),         16'h0000, 16'h0212},
        {ev(E_STP),               16'h0000, 16'h0012},
        {ev(E_TXW),               16'h0000, 16'h0013},
        {ev(E_TXW),               16'h0000, 16'h0093},
        {ev(E_TXS),               16'h0000, 16'h4092},
        {ev(E_ACK, E_NACK),       16'h0000, 16'h8092},
        {ev(E_COL, E_WE),         16'h0000, 16'h8412},
        {ev(E_WE),                16'hFFFF, 16'h8412},
        {ev(E_ACK, E_BD),         16'h0000, 16'h0432},
        {ev(E_STA, E_A10),        16'h0000, 16'h052A},
        {ev(E_AM, E_RW, E_SRX),   16'h0000, 16'h052E},
        {ev(E_TXW, E_BSY),        16'h0000, 16'h05AE},
        {ev(E_TXW, E_TXS),        16'h0000, 16'h45AF},
        {ev(E_WE),                16'h0000, 16'h412F},
        {ev(E_STP, E_STA),        16'h0000, 16'h403B},
        {ev(E_ACK, E_NACK, E_TXS),16'h0000, 16'hC03A},
        {'0,                      16'h0000, 16'hC03A},
        {ev(E_AM),                16'h0000, 16'hC01A},
        {ev(E_SRX),               16'h0000, 16'hC03A}
    };

    localparam string TAG [N_VEC] = '{
        "R9", "R10", "R7", "R7", "R7", "R7", "R7", "R7", "R11", "R5",
        "R5", "R6", "R6", "R3", "R2", "R4", "R11", "R8", "R5", "R8",
        "R6", "R6", "R4", "R9", "R3", "R2", "R8", "R8"
    };

    logic [EV_W-1:0]   evs = '0;
    logic [STAT_W-1:0] wdata = '0;
    logic [STAT_W-1:0] stat_word;
    logic f_nack, f_tx_busy, f_collision, f_gen_call, f_addr10, f_wr_coll, f_rx_ovf;
    logic f_data, f_stop, f_start, f_read, f_rx_full, f_tx_full;

    i2c_stat_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_ack_done(evs[E_ACK]), .ack_nack(evs[E_NACK]), .ev_tx_start(evs[E_TXS]),
        .ev_collision(evs[E_COL]), .ev_gc_match(evs[E_GC]), .ev_addr10_match(evs[E_A10]),
        .ev_addr_match(evs[E_AM]), .addr_rw(evs[E_RW]), .ev_stop(evs[E_STP]),
        .ev_start(evs[E_STA]), .ev_tx_write(evs[E_TXW]), .engine_busy(evs[E_BSY]),
        .ev_rx_xfer(evs[E_RXX]), .ev_rx_read(evs[E_RXR]), .ev_byte_done(evs[E_BD]),
        .ev_slave_rx(evs[E_SRX]), .sw_we(evs[E_WE]), .sw_wdata(wdata),
        .stat_word(stat_word), .f_nack(f_nack), .f_tx_busy(f_tx_busy),
        .f_collision(f_collision), .f_gen_call(f_gen_call), .f_addr10(f_addr10),
        .f_wr_coll(f_wr_coll), .f_rx_ovf(f_rx_ovf), .f_data(f_data), .f_stop(f_stop),
        .f_start(f_start), .f_read(f_read), .f_rx_full(f_rx_full), .f_tx_full(f_tx_full)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [STAT_W-1:0] act,
                         input logic [STAT_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [STAT_W-1:0] flags_word();
        return {f_nack, f_tx_busy, 3'b000, f_collision, f_gen_call, f_addr10,
                f_wr_coll, f_rx_ovf, f_data, f_stop, f_start, f_read, f_rx_full, f_tx_full};
    endfunction

    // Apply one cycle of events at a falling edge, sample at the next one.
    task automatic step(input logic [EV_W-1:0] e, input logic [STAT_W-1:0] d);
        evs = e;
        wdata = d;
        @(negedge clk);
        evs = '0;
        wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset word", stat_word, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", stat_word, 16'h0000);

        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i][VEC_W-1 -: EV_W], VEC[i][2*STAT_W-1 -: STAT_W]);
            check($sformatf("%s row %0d", TAG[i], i), stat_word, VEC[i][STAT_W-1:0]);
        end
        // R12: flag ports mirror the word
        check("R12 flag ports", flags_word(), stat_word);

        // R1: software write of all ones never shows in unimplemented bits
        step(ev(E_WE), 16'hFFFF);
        check("R1 bits 13..11 after write", {13'd0, stat_word[13:11]}, 16'h0000);

        // R10/R9: Stop alone clears read direction and start flag
        step(ev(E_AM, E_RW), 16'h0000);
        check("R10 read loaded", {15'd0, stat_word[2]}, 16'h0001);
        step(ev(E_STP), 16'h0000);
        check("R10 read cleared by stop", {13'd0, stat_word[4:2]}, 16'h0004);

        // R7: fresh overflow sequence, empty then full
        step(ev(E_RXR), 16'h0000);
        step(ev(E_WE), 16'h0000);
        step(ev(E_RXX), 16'h0000);
        check("R7 empty transfer no overflow", {14'd0, stat_word[6], stat_word[1]}, 16'h0001);
        step(ev(E_RXX), 16'h0000);
        check("R7 full transfer overflow", {14'd0, stat_word[6], stat_word[1]}, 16'h0003);
        step(ev(E_WE), 16'h0040);
        check("R7 writing one keeps overflow", {15'd0, stat_word[6]}, 16'h0001);
        step(ev(E_RXX, E_WE), 16'h0000);
        check("R7 set beats software clear", {15'd0, stat_word[6]}, 16'h0001);

        // R6: accepted write, then tx_start clears full
        step(ev(E_TXS), 16'h0000);
        step(ev(E_WE), 16'h0000);
        step(ev(E_TXW, E_BSY), 16'h0000);
        check("R6 busy write rejected", {14'd0, stat_word[7], stat_word[0]}, 16'h0002);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        #1;
        check("R1 async reset clears", stat_word, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 flags after reset", flags_word(), 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule